// File: doc/BRIEF.md
# Register Logic Execute Unit

This unit decodes and executes the bitwise logic instructions of a 32-bit RISC core in a single registered stage. Each cycle in which `valid_i` is high it takes a 32-bit instruction word, the whole 16 x 32-bit register file as one flat vector, the address of the current instruction and the status flags. One clock later it presents the result, a write-back request with its destination index, new values for the N and Z flags with per-flag update strobes, a branch request when register 15 is the destination, and an illegal-instruction indication.

Three encodings are handled. In the compact form the 16-bit instruction sits in bits [31:16]; it covers two-operand AND, OR, exclusive OR, AND-NOT, a flag-only test, and one's complement. In the shifted extended form the first operand is combined with a second operand that has been shifted logically by an immediate amount. In the conditional extended form the write happens only when one of sixteen flag conditions holds. For the extended forms, bits [31:16] hold the first halfword and bits [15:0] hold the second halfword.

Top module: `rlx_exec`

## Requirements
- R1: Compact form: bits [31:29]=000, Rs in [28:25], opcode in [24:20], Rd in [19:16]. Opcode 0x4 gives Rd|Rs, 0x5 gives Rd^Rs, 0x6 gives Rd&Rs and 0x8 gives Rd&~Rs. Each result is written to Rd, N is set to result bit 31, Z is set when the result is zero, and both update strobes are high.
- R2: Compact opcode 0x7 (test) computes Rd&Rs. It updates N and Z only, with no write-back and no branch, and this also holds when Rd is 15.
- R3: Bits [31:20]=0x5CD complement Rd (index in [19:16]) and write the result to Rd. Only Z is updated and the N strobe stays low. The N strobe is never high without the Z strobe.
- R4: Shifted form: bits [31:29]=111, Rx in [28:25], [24:20]=0x1E, Ry in [19:16], selector in [15:9], shift amount in [8:4] and Rd in [3:0]. The selectors are 0x00 AND with a left shift, 0x01 AND with a right shift, 0x08 OR left, 0x09 OR right, 0x10 exclusive OR left and 0x11 exclusive OR right. The result is Rx op (Ry shifted), with logical shifts of 0 to 31 bits, and N and Z are updated.
- R5: Conditional form: bits [24:20]=0x1D and [15:12]=0xE, condition in [11:8], operation in [7:4] (2 AND, 3 OR, 4 exclusive OR) and Rd in [3:0]. It computes Rx op Ry and writes only when the condition holds. It never updates any flag.
- R6: flags_i bit order is [0]=C, [1]=Z, [2]=N, [3]=V, [4]=Q. The condition codes 0 to 15 are Z, !Z, !C, C, N==V, N!=V, N, !N, C|Z, !Z&(N==V), Z|(N!=V), !C&!Z, V, !V, Q and always-true.
- R7: When the destination of a writing instruction is 15, branch_o is high with result_o as the target, and wr_en_o stays low.
- R8: In the compact two-operand forms that write (not the test), a destination of 15 uses pc_i in place of the old Rd value.
- R9: Any other encoding raises illegal_o and suppresses write-back, branch and flag updates.
- R10: Outputs are registered and appear one cycle after valid_i. After reset, and in any cycle following one without valid_i, valid_o, wr_en_o, branch_o, illegal_o and the flag strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word (compact form in [31:16]) |
| pc_i | input | 32 | Address of the current instruction |
| rf_i | input | NREG*32 | Register file, entry i in bits [32i+31:32i] |
| flags_i | input | 5 | Status flags {Q,V,N,Z,C} |
| valid_o | output | 1 | Result stage holds an instruction |
| result_o | output | 32 | Computed value or branch target |
| wr_en_o | output | 1 | Write result to register wr_idx_o |
| wr_idx_o | output | $clog2(NREG) | Destination register index |
| flag_n_o | output | 1 | New N value |
| flag_z_o | output | 1 | New Z value |
| upd_n_o | output | 1 | N flag update strobe |
| upd_z_o | output | 1 | Z flag update strobe |
| branch_o | output | 1 | Jump to result_o requested |
| illegal_o | output | 1 | Instruction not recognised |

## Verification
The bench builds the unit with its default of 16 registers, so every 4-bit register field in the encodings addresses a real entry. Register 15 can therefore be used both as the program-counter destination and as an ordinary test source. With that size the bench can reach the PC substitution, the branch-instead-of-write path, and the test instruction reading register 15 as data. It also sweeps all sixteen condition codes against flag patterns that separate the signed, unsigned and saturation conditions.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
  parameter int unsigned RLX_XLEN = 32;
  localparam int unsigned RLX_SAW = $clog2(RLX_XLEN);

  typedef enum logic [2:0] {
    LOP_AND, LOP_OR, LOP_EOR, LOP_ANDN, LOP_COM
  } lop_e;

  typedef struct packed {
    logic       legal;
    lop_e       op;
    logic [3:0] ra;
    logic [3:0] rb;
    logic [3:0] rd;
    logic       use_pc;
    logic       shr;
    logic [RLX_SAW-1:0] sa;
    logic       wr;
    logic       set_n;
    logic       set_z;
    logic       is_cond;
    logic [3:0] cc;
  } dec_t;

  // flags: [0]=C [1]=Z [2]=N [3]=V [4]=Q
  function automatic logic cond_true(input logic [3:0] cc, input logic [4:0] fl);
    logic c, z, n, v, q;
    {q, v, n, z, c} = fl;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return !c;
      4'd3:  return c;
      4'd4:  return n == v;
      4'd5:  return n != v;
      4'd6:  return n;
      4'd7:  return !n;
      4'd8:  return c | z;
      4'd9:  return !z && (n == v);
      4'd10: return z || (n != v);
      4'd11: return !c && !z;
      4'd12: return v;
      4'd13: return !v;
      4'd14: return q;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [RLX_XLEN-1:0] shift_op(input logic [RLX_XLEN-1:0] b,
                                                  input logic shr,
                                                  input logic [RLX_SAW-1:0] sa);
    return shr ? (b >> sa) : (b << sa);
  endfunction

  function automatic logic [RLX_XLEN-1:0] logic_op(input lop_e op,
                                                  input logic [RLX_XLEN-1:0] a,
                                                  input logic [RLX_XLEN-1:0] b);
    case (op)
      LOP_AND:  return a & b;
      LOP_OR:   return a | b;
      LOP_EOR:  return a ^ b;
      LOP_ANDN: return a & ~b;
      default:  return ~a;
    endcase
  endfunction
endpackage

// File: rtl/rlx_decode.sv
module rlx_decode import rlx_pkg::*; (
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [15:0] hi, lo;
  assign hi = instr_i[31:16];
  assign lo = instr_i[15:0];

  always_comb begin
    dec_o = '0;
    dec_o.op = LOP_AND;
    if (hi[15:4] == 12'h5CD) begin
      dec_o.legal = 1'b1;
      dec_o.op    = LOP_COM;
      dec_o.ra    = hi[3:0];
      dec_o.rd    = hi[3:0];
      dec_o.wr    = 1'b1;
      dec_o.set_z = 1'b1;
    end else if (hi[15:13] == 3'b000) begin
      dec_o.ra    = hi[3:0];
      dec_o.rb    = hi[12:9];
      dec_o.rd    = hi[3:0];
      dec_o.set_n = 1'b1;
      dec_o.set_z = 1'b1;
      dec_o.legal = 1'b1;
      dec_o.wr    = 1'b1;
      case (hi[8:4])
        5'h4: dec_o.op = LOP_OR;
        5'h5: dec_o.op = LOP_EOR;
        5'h6: dec_o.op = LOP_AND;
        5'h7: begin dec_o.op = LOP_AND; dec_o.wr = 1'b0; end
        5'h8: dec_o.op = LOP_ANDN;
        default: dec_o.legal = 1'b0;
      endcase
      dec_o.use_pc = dec_o.wr && (hi[3:0] == 4'hF);
    end else if (hi[15:13] == 3'b111 && hi[8:4] == 5'h1E) begin
      dec_o.ra    = hi[12:9];
      dec_o.rb    = hi[3:0];
      dec_o.rd    = lo[3:0];
      dec_o.sa    = lo[8:4];
      dec_o.shr   = lo[9];
      dec_o.wr    = 1'b1;
      dec_o.set_n = 1'b1;
      dec_o.set_z = 1'b1;
      dec_o.legal = 1'b1;
      case (lo[15:10])
        6'h00: dec_o.op = LOP_AND;
        6'h04: dec_o.op = LOP_OR;
        6'h08: dec_o.op = LOP_EOR;
        default: dec_o.legal = 1'b0;
      endcase
    end else if (hi[15:13] == 3'b111 && hi[8:4] == 5'h1D && lo[15:12] == 4'hE) begin
      dec_o.ra      = hi[12:9];
      dec_o.rb      = hi[3:0];
      dec_o.rd      = lo[3:0];
      dec_o.cc      = lo[11:8];
      dec_o.is_cond = 1'b1;
      dec_o.wr      = 1'b1;
      dec_o.legal   = 1'b1;
      case (lo[7:4])
        4'h2: dec_o.op = LOP_AND;
        4'h3: dec_o.op = LOP_OR;
        4'h4: dec_o.op = LOP_EOR;
        default: dec_o.legal = 1'b0;
      endcase
    end
    if (!dec_o.legal) begin
      dec_o.wr    = 1'b0;
      dec_o.set_n = 1'b0;
      dec_o.set_z = 1'b0;
    end
  end
endmodule

// File: rtl/rlx_cond.sv
module rlx_cond import rlx_pkg::*; (
  input  logic [3:0] cc_i,
  input  logic [4:0] flags_i,
  output logic       hold_o
);
  assign hold_o = cond_true(cc_i, flags_i);
endmodule

// File: rtl/rlx_alu.sv
module rlx_alu import rlx_pkg::*; #(
  parameter int NREG = 16
) (
  input  dec_t                     dec_i,
  input  logic [NREG*RLX_XLEN-1:0] rf_i,
  input  logic [RLX_XLEN-1:0]      pc_i,
  output logic [RLX_XLEN-1:0]      res_o
);
  logic [RLX_XLEN-1:0] regs [NREG];
  logic [RLX_XLEN-1:0] opa, opb;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign regs[g] = rf_i[g*RLX_XLEN +: RLX_XLEN];
  end

  assign opa   = dec_i.use_pc ? pc_i : regs[dec_i.ra];
  assign opb   = shift_op(regs[dec_i.rb], dec_i.shr, dec_i.sa);
  assign res_o = logic_op(dec_i.op, opa, opb);
endmodule

// File: rtl/rlx_exec.sv
module rlx_exec import rlx_pkg::*; #(
  parameter int NREG = 16,
  localparam int XLEN = RLX_XLEN,
  localparam int RIW  = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [31:0]          instr_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [NREG*XLEN-1:0] rf_i,
  input  logic [4:0]           flags_i,
  output logic                 valid_o,
  output logic [XLEN-1:0]      result_o,
  output logic                 wr_en_o,
  output logic [RIW-1:0]       wr_idx_o,
  output logic                 flag_n_o,
  output logic                 flag_z_o,
  output logic                 upd_n_o,
  output logic                 upd_z_o,
  output logic                 branch_o,
  output logic                 illegal_o
);
  dec_t            dec;
  logic            cond_hold;
  logic            commit;
  logic            dest_pc;
  logic [XLEN-1:0] res;

  rlx_decode u_dec (.instr_i(instr_i), .dec_o(dec));
  rlx_cond   u_cnd (.cc_i(dec.cc), .flags_i(flags_i), .hold_o(cond_hold));
  rlx_alu #(.NREG(NREG)) u_alu (.dec_i(dec), .rf_i(rf_i), .pc_i(pc_i), .res_o(res));

  assign commit  = valid_i && dec.legal && dec.wr && (!dec.is_cond || cond_hold);
  assign dest_pc = (dec.rd == 4'hF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      flag_n_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      upd_n_o   <= 1'b0;
      upd_z_o   <= 1'b0;
      branch_o  <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      result_o  <= res;
      wr_en_o   <= commit && !dest_pc;
      wr_idx_o  <= dec.rd[RIW-1:0];
      flag_n_o  <= res[XLEN-1];
      flag_z_o  <= (res == '0);
      upd_n_o   <= valid_i && dec.set_n;
      upd_z_o   <= valid_i && dec.set_z;
      branch_o  <= commit && dest_pc;
      illegal_o <= valid_i && !dec.legal;
    end
  end

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wr_en_o && !branch_o && !upd_n_o && !upd_z_o);
  // R7
  pc_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_o |-> !wr_en_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !(wr_en_o || branch_o || illegal_o || upd_n_o || upd_z_o));
  // R3
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_n_o |-> upd_z_o);
  // R5
  cond_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dec.legal && dec.is_cond && !cond_hold) |=> !wr_en_o && !branch_o && !upd_z_o);
  // R6
  always_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dec.legal && dec.is_cond && dec.cc == 4'hF) |=> (wr_en_o || branch_o));
endmodule

// File: tb/sim_rlx_exec.sv
module sim_rlx_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic [511:0] rf_i;
  logic [4:0]  flags_i = '0;
  logic        valid_o, wr_en_o, flag_n_o, flag_z_o, upd_n_o, upd_z_o, branch_o, illegal_o;
  logic [31:0] result_o;
  logic [3:0]  wr_idx_o;
  logic [31:0] rv [16];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < 16; i++) rf_i[i*32 +: 32] = rv[i];

  rlx_exec u0 (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
    .rf_i(rf_i), .flags_i(flags_i), .valid_o(valid_o), .result_o(result_o), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .upd_n_o(upd_n_o),
    .upd_z_o(upd_z_o), .branch_o(branch_o), .illegal_o(illegal_o));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkb(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] ins, logic [31:0] pc, logic [4:0] fl);
    @(negedge clk);
    instr_i = ins; pc_i = pc; flags_i = fl; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  function automatic logic [31:0] enc_cmp(logic [4:0] opc, logic [3:0] rs, logic [3:0] rd);
    return {3'b000, rs, opc, rd, 16'h0000};
  endfunction
  function automatic logic [31:0] enc_shf(logic [6:0] sel, logic [3:0] x, logic [3:0] y,
                                          logic [4:0] sa, logic [3:0] d);
    return {3'b111, x, 5'h1E, y, sel, sa, d};
  endfunction
  function automatic logic [31:0] enc_cnd(logic [3:0] c, logic [3:0] opc, logic [3:0] x,
                                          logic [3:0] y, logic [3:0] d);
    return {3'b111, x, 5'h1D, y, 4'hE, c, opc, d};
  endfunction

  function automatic bit exp_cc(int c, logic [4:0] f);
    bit cf = f[0], zf = f[1], nf = f[2], vf = f[3], qf = f[4];
    case (c)
      0: return zf;           1: return !zf;
      2: return !cf;          3: return cf;
      4: return (nf && vf) || (!nf && !vf);
      5: return nf ^ vf;      6: return nf;
      7: return !nf;          8: return cf || zf;
      9: return !zf && !(nf ^ vf);
      10: return zf || (nf ^ vf);
      11: return !(cf || zf); 12: return vf;
      13: return !vf;         14: return qf;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] exp_op(int k, logic [31:0] a, logic [31:0] b);
    case (k)
      0: return a | b;
      1: return (a | b) & ~(a & b);
      2: return a & b;
      default: return a & ~b;
    endcase
  endfunction

  task automatic t_reset();
    chkb("R10", "valid after reset", valid_o, 1'b0);
    chkb("R10", "wr after reset", wr_en_o, 1'b0);
    chkb("R10", "branch after reset", branch_o, 1'b0);
    chkb("R10", "illegal after reset", illegal_o, 1'b0);
  endtask

  task automatic t_compact();
    logic [4:0] opc [4] = '{5'h4, 5'h5, 5'h6, 5'h8};
    int prs [4] = '{1, 2, 6, 3};
    int prd [4] = '{4, 7, 0, 4};
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] e = exp_op(k, rv[prd[p]], rv[prs[p]]);
        issue(enc_cmp(opc[k], 4'(prs[p]), 4'(prd[p])), 32'h0, 5'h0);
        chk("R1", "compact result", result_o, e);
        chkb("R1", "compact wr", wr_en_o, 1'b1);
        chk("R1", "compact idx", {28'h0, wr_idx_o}, 32'(prd[p]));
        chkb("R1", "compact N", flag_n_o, e[31]);
        chkb("R1", "compact Z", flag_z_o, e == 0);
        chkb("R1", "compact updN", upd_n_o, 1'b1);
        chkb("R10", "valid one cycle later", valid_o, 1'b1);
      end
    end
    @(negedge clk);
    chkb("R10", "valid after idle", valid_o, 1'b0);
  endtask

  task automatic t_tst();
    issue(enc_cmp(5'h7, 4'd2, 4'd4), 32'h0, 5'h0);
    chkb("R2", "tst wr", wr_en_o, 1'b0);
    chkb("R2", "tst N", flag_n_o, 1'b1);
    chkb("R2", "tst Z", flag_z_o, 1'b0);
    chkb("R2", "tst updZ", upd_z_o, 1'b1);
    issue(enc_cmp(5'h7, 4'd1, 4'd15), 32'h0000_4000, 5'h0);
    chk("R2", "tst r15 value", result_o, 32'h0204_1230);
    chkb("R2", "tst r15 no branch", branch_o, 1'b0);
    issue(enc_cmp(5'h7, 4'd3, 4'd4), 32'h0, 5'h0);
    chkb("R2", "tst zero Z", flag_z_o, 1'b1);
  endtask

  task automatic t_com();
    issue({12'h5CD, 4'd4, 16'h0}, 32'h0, 5'h0);
    chk("R3", "com result", result_o, 32'h5A5A_A5A5);
    chkb("R3", "com wr", wr_en_o, 1'b1);
    chkb("R3", "com updN", upd_n_o, 1'b0);
    chkb("R3", "com updZ", upd_z_o, 1'b1);
    chkb("R3", "com Z", flag_z_o, 1'b0);
    issue({12'h5CD, 4'd9, 16'h0}, 32'h0, 5'h0);
    chk("R3", "com zero", result_o, 32'h0);
    chkb("R3", "com zero Z", flag_z_o, 1'b1);
  endtask

  task automatic t_shift();
    logic [6:0] sel [6] = '{7'h00, 7'h01, 7'h08, 7'h09, 7'h10, 7'h11};
    int sa [6] = '{4, 31, 0, 16, 31, 1};
    for (int k = 0; k < 6; k++) begin
      logic [31:0] y = rv[7];
      logic [31:0] ys = k[0] ? (y >> sa[k]) : (y << sa[k]);
      logic [31:0] x = rv[1];
      logic [31:0] e = (k < 2) ? (x & ys) : (k < 4) ? (x | ys) : (x ^ ys);
      issue(enc_shf(sel[k], 4'd1, 4'd7, 5'(sa[k]), 4'd10), 32'h0, 5'h0);
      chk("R4", "shift result", result_o, e);
      chkb("R4", "shift wr", wr_en_o, 1'b1);
      chkb("R4", "shift N", flag_n_o, e[31]);
      chkb("R4", "shift updN", upd_n_o, 1'b1);
    end
  endtask

  task automatic t_cond();
    logic [4:0] pats [6] = '{5'b00000, 5'b00011, 5'b00100, 5'b01000, 5'b10000, 5'b01100};
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 6; p++) begin
        int k = (c + p) % 3;
        bit h = exp_cc(c, pats[p]);
        logic [31:0] e = (k == 0) ? (rv[4] & rv[1]) : (k == 1) ? (rv[4] | rv[1]) : (rv[4] ^ rv[1]);
        issue(enc_cnd(4'(c), 4'(k + 2), 4'd4, 4'd1, 4'd11), 32'h0, pats[p]);
        chkb("R6", $sformatf("cond %0d flags %b", c, pats[p]), wr_en_o, h);
        chkb("R5", "cond no flag update", upd_z_o | upd_n_o, 1'b0);
        if (h) chk("R5", "cond result", result_o, e);
      end
    end
  endtask

  task automatic t_branch();
    issue(enc_cmp(5'h4, 4'd1, 4'd15), 32'h0000_1000, 5'h0);
    chk("R8", "or pc target", result_o, 32'h0F0F_1234 | 32'h0000_1000);
    chkb("R7", "or pc branch", branch_o, 1'b1);
    chkb("R7", "or pc no wr", wr_en_o, 1'b0);
    issue(enc_cmp(5'h8, 4'd2, 4'd15), 32'h1234_ABCC, 5'h0);
    chk("R8", "andn pc target", result_o, 32'h0000_ABCC);
    issue(enc_shf(7'h08, 4'd2, 4'd5, 5'd3, 4'd15), 32'h0, 5'h0);
    chk("R7", "shift r15 target", result_o, 32'hFFFF_0008);
    chkb("R7", "shift r15 branch", branch_o, 1'b1);
    issue(enc_cnd(4'hF, 4'h4, 4'd4, 4'd1, 4'd15), 32'h0, 5'h0);
    chk("R7", "cond r15 target", result_o, rv[4] ^ rv[1]);
    chkb("R7", "cond r15 branch", branch_o, 1'b1);
    issue(enc_cnd(4'h0, 4'h3, 4'd4, 4'd1, 4'd15), 32'h0, 5'h0);
    chkb("R5", "cond false no branch", branch_o, 1'b0);
    issue({12'h5CD, 4'd15, 16'h0}, 32'h0, 5'h0);
    chk("R7", "com r15 target", result_o, ~32'h1234_5678);
    chkb("R7", "com r15 branch", branch_o, 1'b1);
  endtask

  task automatic t_illegal();
    logic [31:0] bad [5];
    bad[0] = enc_cmp(5'h3, 4'd1, 4'd2);
    bad[1] = enc_shf(7'h02, 4'd1, 4'd2, 5'd1, 4'd3);
    bad[2] = enc_cnd(4'hF, 4'h5, 4'd1, 4'd2, 4'd3);
    bad[3] = {3'b111, 4'd1, 5'h1D, 4'd2, 4'hD, 4'hF, 4'h2, 4'd3};
    bad[4] = 32'hFFFF_FFFF;
    for (int i = 0; i < 5; i++) begin
      issue(bad[i], 32'h0, 5'h0);
      chkb("R9", $sformatf("illegal %0d flag", i), illegal_o, 1'b1);
      chkb("R9", "illegal no wr", wr_en_o, 1'b0);
      chkb("R9", "illegal no branch", branch_o, 1'b0);
      chkb("R9", "illegal no flags", upd_n_o | upd_z_o, 1'b0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rv[i] = 32'h0101_0101 * (i + 1);
    rv[0] = 32'h8000_00F0; rv[1] = 32'h0F0F_1234; rv[2] = 32'hFFFF_0000;
    rv[3] = 32'h0;         rv[4] = 32'hA5A5_5A5A; rv[5] = 32'h0000_0001;
    rv[6] = 32'h7FFF_FFFF; rv[7] = 32'hDEAD_BEEF; rv[9] = 32'hFFFF_FFFF;
    rv[15] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_compact();
    t_tst();
    t_com();
    t_shift();
    t_cond();
    t_branch();
    t_illegal();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule